// File: doc/BRIEF.md
# I2C Target Byte Summer

This block is an I2C target with one fixed 7-bit address. A bus master writes a stream of bytes to it, and the block adds each byte to a 16-bit running total. The master can then read that total back as two bytes, high byte first. The block samples SCL and SDA with a fast system clock, so the bus rate only has to stay well below the system clock rate. The intended operating point is a 50 kHz bus with a 16 MHz system clock.

Whether the total is cleared depends on a small transaction state machine, not on the direction of the transfer. The first address match after the machine returns to its waiting state clears the total. Any later match keeps it. So a write, then a repeated START, then a read returns the sum of the write. The machine returns to waiting when the master answers a byte sent by the block with a not-acknowledge.

On the pin side, the block takes the SCL and SDA levels as inputs. It has one output that pulls SDA low when high; the pad or board supplies the open-drain wiring and the pull-ups.

Top module: `i2c_sum_target`

## Requirements
- R1: The block answers only to 7-bit address 0x50, sent as the upper seven bits of the first byte after a START (bit 0 is the direction, 1 = read). For any other address it gives no acknowledge and leaves SDA released until the next START, and bytes sent in that transfer do not change the total.
- R2: The block pulls SDA low during the ninth clock of every matching address byte and of every data byte it receives.
- R3: An address match while the state machine is waiting sets the total to zero. This holds for both write and read direction.
- R4: Each received data byte is added to the total as an unsigned value, and the total wraps modulo 65536.
- R5: An address match while the state machine is not waiting leaves the total unchanged. This applies after a repeated START and after a STOP followed by a new START.
- R6: In a read, the first byte returned is bits 15..8 of the total and every following byte is bits 7..0. Each byte is sent most significant bit first.
- R7: A not-acknowledge from the master after a byte sent by the block returns the state machine to waiting, so the next address match clears the total.
- R8: A START or repeated START in the middle of a byte discards the partial byte and restarts bit counting at the address byte.
- R9: The block changes its SDA drive only while the synchronised SCL is low. It releases SDA for the master's acknowledge bit.
- R10: After reset, SDA is released and the state machine is waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |

## Verification
A wrong transaction state does not show right away. It shows on the next read, as a wrong byte order or a total that was cleared when it should have been kept, or kept when it should have been cleared. It can also show on a later write that fails to restart the sum. A wrong bit counter or address compare shows within one byte time: an acknowledge is missing or in the wrong slot, or the block drives SDA during a transfer meant for another device. Arithmetic faults show only in the values read back, so the scenarios cover carries into the high byte and a wrap past 0xFFFF.

// File: rtl/sumtgt_pkg.sv
// Package: types shared by the I2C byte-summing target.
// Assumes 8-bit bus bytes and a 7-bit address.
package sumtgt_pkg;

    localparam int BYTE_W = 8;

    // Transaction level: decides clearing of the total and which byte goes out next
    typedef enum logic [1:0] {
        TS_WAIT,
        TS_ADD,
        TS_SENT_HI,
        TS_SENT_LO
    } txn_state_t;

    // Bit level: where the link engine is inside a byte and its acknowledge slot
    typedef enum logic [2:0] {
        LP_IDLE,
        LP_ADDR,
        LP_ACK_WAIT,
        LP_ACK_DRIVE,
        LP_RX,
        LP_TX,
        LP_TX_ACK,
        LP_TX_LOAD
    } link_phase_t;

endpackage

// File: rtl/sumtgt_sync.sv
// Module: synchronises SCL and SDA into the system clock domain and flags
// SCL edges plus START and STOP conditions.
// Assumes the bus is idle-high at reset and the system clock is many times
// faster than SCL. STAGES must be at least 2.
module sumtgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Synchroniser chain, one flop per stage per line
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe[0] <= 1'b1;
                    sda_pipe[0] <= 1'b1;
                end else begin
                    scl_pipe[0] <= scl_i;
                    sda_pipe[0] <= sda_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe[g] <= 1'b1;
                    sda_pipe[g] <= 1'b1;
                end else begin
                    scl_pipe[g] <= scl_pipe[g-1];
                    sda_pipe[g] <= sda_pipe[g-1];
                end
            end
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // Previous synchronised levels, used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Edge and bus-condition decode
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/sumtgt_link.sv
// Module: bit-level target engine. Shifts in the address and data bytes,
// drives the acknowledge, shifts out read bytes MSB first and reports
// one-cycle events to the transaction logic.
// Assumes SCL edges come from the synchroniser. SDA drive changes only on a
// detected SCL fall. A read byte must be ready in tx_byte by the next SCL
// fall after tx_req.
module sumtgt_link
    import sumtgt_pkg::*;
#(
    parameter int          ADDR_W   = 7,
    parameter logic [6:0]  DEV_ADDR = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sda_oe,
    output logic              addr_hit,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    output logic              tx_req,
    output logic              mst_nack,
    output logic              link_idle
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    link_phase_t       phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              rd_q;

    assign link_idle = (phase == LP_IDLE);

    // Bit engine: one phase step per qualifying SCL edge, conditions override
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= LP_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            rd_q     <= 1'b0;
            sda_oe   <= 1'b0;
            addr_hit <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            tx_req   <= 1'b0;
            mst_nack <= 1'b0;
        end else begin
            addr_hit <= 1'b0;
            rx_valid <= 1'b0;
            tx_req   <= 1'b0;
            mst_nack <= 1'b0;
            if (start_det) begin
                phase   <= LP_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                phase   <= LP_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                unique case (phase)
                    LP_ADDR, LP_RX: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            if (bit_cnt == LAST_BIT) begin
                                bit_cnt <= '0;
                                if (phase == LP_ADDR) begin
                                    if (shreg[ADDR_W-1:0] == DEV_ADDR) begin
                                        addr_hit <= 1'b1;
                                        rd_q     <= sda_s;
                                        phase    <= LP_ACK_WAIT;
                                    end else begin
                                        phase    <= LP_IDLE;
                                    end
                                end else begin
                                    rx_valid <= 1'b1;
                                    rx_data  <= {shreg[BYTE_W-2:0], sda_s};
                                    rd_q     <= 1'b0;
                                    phase    <= LP_ACK_WAIT;
                                end
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    LP_ACK_WAIT: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b1;
                            tx_req <= rd_q;
                            phase  <= LP_ACK_DRIVE;
                        end
                    end
                    LP_ACK_DRIVE: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rd_q) begin
                                shreg  <= tx_byte;
                                sda_oe <= ~tx_byte[BYTE_W-1];
                                phase  <= LP_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                phase  <= LP_RX;
                            end
                        end
                    end
                    LP_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == LAST_BIT) begin
                                bit_cnt <= '0;
                                sda_oe  <= 1'b0;
                                phase   <= LP_TX_ACK;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe  <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    LP_TX_ACK: begin
                        if (scl_rise) begin
                            if (sda_s) begin
                                mst_nack <= 1'b1;
                                phase    <= LP_IDLE;
                            end else begin
                                tx_req   <= 1'b1;
                                phase    <= LP_TX_LOAD;
                            end
                        end
                    end
                    LP_TX_LOAD: begin
                        if (scl_fall) begin
                            shreg  <= tx_byte;
                            sda_oe <= ~tx_byte[BYTE_W-1];
                            phase  <= LP_TX;
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/sumtgt_txn.sv
// Module: transaction state machine and running total. Acts on link events:
// clears on the first address match after waiting, adds received bytes and
// picks the high or low byte for each read request.
// Assumes link events are single-cycle and never coincide.
module sumtgt_txn
    import sumtgt_pkg::*;
#(
    parameter int SUM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_hit,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              tx_req,
    input  logic              mst_nack,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [SUM_W-1:0]  sum_q,
    output txn_state_t        state_q
);

    localparam int PAD_W = SUM_W - BYTE_W;

    logic [SUM_W-1:0] rx_ext;

    assign rx_ext = {{PAD_W{1'b0}}, rx_data};

    // Total, state and outgoing byte updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TS_WAIT;
            sum_q   <= '0;
            tx_byte <= '0;
        end else begin
            if (addr_hit) begin
                if (state_q == TS_WAIT) begin
                    sum_q   <= '0;
                    state_q <= TS_ADD;
                end
            end else if (rx_valid) begin
                sum_q   <= sum_q + rx_ext;
                state_q <= TS_ADD;
            end else if (tx_req) begin
                if (state_q == TS_ADD) begin
                    tx_byte <= sum_q[SUM_W-1 -: BYTE_W];
                    state_q <= TS_SENT_HI;
                end else begin
                    tx_byte <= sum_q[BYTE_W-1:0];
                    state_q <= TS_SENT_LO;
                end
            end else if (mst_nack) begin
                state_q <= TS_WAIT;
            end
        end
    end

endmodule

// File: rtl/i2c_sum_target.sv
// Module: top of the I2C byte-summing target. Chains synchroniser, bit
// engine and transaction logic. sda_oe high means pull SDA low.
// Assumes external pull-ups and a system clock well above the SCL rate.
module i2c_sum_target
    import sumtgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         SYNC_STAGES = 2,
    parameter int         SUM_W       = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              addr_hit;
    logic              rx_valid;
    logic [BYTE_W-1:0] rx_data;
    logic              tx_req;
    logic              mst_nack;
    logic              link_idle;
    logic [BYTE_W-1:0] tx_byte;
    logic [SUM_W-1:0]  sum_q;
    txn_state_t        state_q;

    sumtgt_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    sumtgt_link #(
        .ADDR_W   (7),
        .DEV_ADDR (DEV_ADDR)
    ) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .tx_byte   (tx_byte),
        .sda_oe    (sda_oe),
        .addr_hit  (addr_hit),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .tx_req    (tx_req),
        .mst_nack  (mst_nack),
        .link_idle (link_idle)
    );

    sumtgt_txn #(
        .SUM_W (SUM_W)
    ) u_txn (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_hit (addr_hit),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .tx_req   (tx_req),
        .mst_nack (mst_nack),
        .tx_byte  (tx_byte),
        .sum_q    (sum_q),
        .state_q  (state_q)
    );

endmodule

// File: rtl/sumtgt_checker.sv
// Module: assertion checker bound to the target top. It relates link events,
// the transaction state and the SDA drive over time.
module sumtgt_checker
    import sumtgt_pkg::*;
#(
    parameter int SUM_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              sda_oe,
    input logic              link_idle,
    input logic              addr_hit,
    input logic              rx_valid,
    input logic [BYTE_W-1:0] rx_data,
    input logic              tx_req,
    input logic              mst_nack,
    input logic [BYTE_W-1:0] tx_byte,
    input logic [SUM_W-1:0]  sum_q,
    input txn_state_t        state_q
);

    logic [SUM_W-1:0] rx_wide;
    assign rx_wide = {{(SUM_W-BYTE_W){1'b0}}, rx_data};

    assert_ignored_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        link_idle |-> !sda_oe);

    assert_clear_from_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_hit && state_q == TS_WAIT) |=> (sum_q == '0 && state_q == TS_ADD));

    assert_byte_added_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (sum_q == $past(sum_q) + $past(rx_wide) && state_q == TS_ADD));

    assert_total_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_hit && state_q != TS_WAIT) |=> $stable(sum_q));

    assert_high_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && state_q == TS_ADD) |=> tx_byte == $past(sum_q[SUM_W-1 -: BYTE_W]));

    assert_low_after_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && state_q != TS_ADD) |=> (tx_byte == $past(sum_q[BYTE_W-1:0]) && state_q == TS_SENT_LO));

    assert_nack_to_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mst_nack |=> state_q == TS_WAIT);

    assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s));

    assert_one_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_hit, rx_valid, tx_req, mst_nack}));

endmodule

bind i2c_sum_target sumtgt_checker #(
    .SUM_W (SUM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_oe    (sda_oe),
    .link_idle (link_idle),
    .addr_hit  (addr_hit),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .tx_req    (tx_req),
    .mst_nack  (mst_nack),
    .tx_byte   (tx_byte),
    .sum_q     (sum_q),
    .state_q   (state_q)
);

// File: tb/sim_i2c_sum_target.sv
`timescale 1ns/1ps
// Bench: bit-banged I2C master with directed scenario tasks. Each task
// checks its own results through the bus.
module sim_i2c_sum_target;

    localparam int CLK_PERIOD = 62;
    localparam int Q          = 8;
    localparam int WATCHDOG   = 190000;
    localparam logic [7:0] A_W   = {7'h50, 1'b0};
    localparam logic [7:0] A_R   = {7'h50, 1'b1};
    localparam logic [7:0] A_BAD = {7'h51, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_bus;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;

    assign sda_bus = m_sda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_sum_target u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (m_scl),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic do_start();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic do_rstart();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic do_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic put_bit(input logic b);
        m_sda = b;    wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        b = sda_bus;  wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic get_byte(input logic ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~ack);
    endtask

    // Reads a two-byte total, NACKing the second byte, then STOP
    task automatic read_total(input string tag, input logic rstart, output logic [15:0] tot);
        logic ack;
        logic [7:0] hi, lo;
        if (rstart) do_rstart(); else do_start();
        put_byte(A_R, ack);
        chk({tag, " R2 read address ack"}, ack, 1);
        get_byte(1'b1, hi);
        get_byte(1'b0, lo);
        do_stop();
        tot = {hi, lo};
    endtask

    task automatic t_reset();
        chk("R10 sda released in reset", sda_oe, 0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 sda released after reset", sda_oe, 0);
        chk("R10 bus idle high", sda_bus, 1);
    endtask

    task automatic t_sum_then_read();
        logic ack;
        logic [15:0] tot;
        int acks = 0;
        do_start();
        put_byte(A_W, ack);
        chk("R2 write address ack", ack, 1);
        for (int i = 1; i <= 10; i++) begin
            put_byte(8'(i), ack);
            if (ack) acks++;
        end
        chk("R2 all data bytes acked", acks, 10);
        read_total("R5 R6", 1'b1, tot);
        chk("R6 high byte first", int'(tot[15:8]), 8'h00);
        chk("R4 sum of 1..10 low byte", int'(tot[7:0]), 8'h37);
        chk("R5 total kept across repeated START", int'(tot), 55);
    endtask

    task automatic t_foreign();
        logic ack;
        logic [15:0] tot;
        do_start();
        put_byte(A_W, ack);
        chk("R3 write address ack", ack, 1);
        put_byte(8'h05, ack);
        do_stop();
        do_start();
        put_byte(A_BAD, ack);
        chk("R1 no ack for address 0x51", ack, 0);
        put_byte(8'h07, ack);
        chk("R1 no ack for data to other device", ack, 0);
        put_byte(8'h00, ack);
        chk("R1 zero byte not acked by other device", ack, 0);
        do_stop();
        read_total("R1", 1'b0, tot);
        chk("R1 R5 foreign bytes ignored, total kept past STOP", int'(tot), 5);
    endtask

    task automatic t_wrap();
        logic ack;
        logic [15:0] tot;
        do_start();
        put_byte(A_W, ack);
        for (int i = 0; i < 257; i++) put_byte(8'hFF, ack);
        chk("R2 ack on 257th byte", ack, 1);
        put_byte(8'h02, ack);
        do_stop();
        read_total("R4", 1'b0, tot);
        chk("R4 total wraps modulo 65536", int'(tot), 16'h0001);
    endtask

    task automatic t_order_and_nack();
        logic ack;
        logic [7:0] b0, b1, b2;
        logic [15:0] tot;
        do_start();
        put_byte(A_W, ack);
        put_byte(8'hFF, ack);
        put_byte(8'hFF, ack);
        put_byte(8'h03, ack);
        do_rstart();
        put_byte(A_R, ack);
        chk("R6 read address ack", ack, 1);
        get_byte(1'b1, b0);
        get_byte(1'b1, b1);
        get_byte(1'b0, b2);
        do_stop();
        chk("R6 first byte is high byte", int'(b0), 8'h02);
        chk("R6 second byte is low byte", int'(b1), 8'h01);
        chk("R6 third byte repeats low byte", int'(b2), 8'h01);
        read_total("R7", 1'b0, tot);
        chk("R7 R3 read after NACK clears total", int'(tot), 0);
    endtask

    task automatic t_abort_byte();
        logic ack;
        logic [15:0] tot;
        do_start();
        put_byte(A_W, ack);
        put_byte(8'h10, ack);
        put_bit(1'b1);
        put_bit(1'b0);
        put_bit(1'b1);
        put_bit(1'b1);
        read_total("R8", 1'b1, tot);
        chk("R8 partial byte discarded", int'(tot), 16'h0010);
    endtask

    initial begin
        t_reset();
        t_sum_then_read();
        t_foreign();
        t_wrap();
        t_order_and_nack();
        t_abort_byte();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule